// File: doc/BRIEF.md
# Per-Bank Refresh Scheduler

This block plans per-bank refresh for one rank of a DRAM controller. An internal cycle timer sets a refresh due point once every per-bank interval. The interval is typically a quarter of the all-bank interval, for example 1560 cycles where the all-bank interval is 6240. At each due point the scheduler looks for a bank that is idle and that has not yet been refreshed in the current round. It then asks the command path for a precharge if that bank is open, or for a per-bank refresh if it is closed.

A signed credit counter records how many refreshes are owed or have been done early. When every candidate bank is busy, the refresh is postponed and the credit rises. Once the credit reaches the postpone limit, the refresh is forced: the chosen bank is blocked from other traffic and stays the target until its refresh is issued. After a regular refresh the scheduler enters a pulled-in state. In that state it keeps refreshing idle banks early, and each early refresh lowers the credit, until the pull-in limit is reached or no candidate is idle.

The surrounding controller reports which command it actually issued, and it reports power-down and self-refresh events. Timing legality and bank state are kept outside this block.

Top module: `bankref_sched`

## Requirements
- R1: After reset, no request is raised and no bank is blocked. The first due point falls INTERVAL cycles after reset release, and a request to an idle, closed bank appears one cycle after that (INTERVAL+1 clock edges after release).
- R2: The target is the lowest-index bank that is both idle and pending. `req_bank_o` is the binary bank index. `req_is_ref_o` is 1 for a per-bank refresh when the target is closed, and 0 for a precharge when the target is open.
- R3: Each `ref_done_i` removes `req_bank_o` from the pending set. When the pending set would become empty, it is refilled with every bank, so it is never empty.
- R4: In the regular state, if no pending bank is idle and the credit is below the postpone limit, no request is made, the credit rises by one, and the due point moves one INTERVAL later.
- R5: When the credit equals MAX_POSTPONE*NUM_BANKS, the refresh is forced to the lowest pending bank even if that bank is busy. The bank is blocked (one-hot `bank_block_o`) and stays the target until `ref_done_i`, which releases the block. The credit always stays within [-MAX_PULLIN*NUM_BANKS, MAX_POSTPONE*NUM_BANKS].
- R6: A refresh issued in the regular state moves the scheduler to the pulled-in state without changing the credit. Each refresh issued in the pulled-in state lowers the credit by one. Reaching -MAX_PULLIN*NUM_BANKS returns the scheduler to the regular state and moves the due point one INTERVAL later, so no request follows until then.
- R7: In the pulled-in state, if no pending bank is idle, the scheduler returns to the regular state and moves the due point one INTERVAL later, without making a request.
- R8: If the due point lies a full INTERVAL in the past, it advances by one INTERVAL and the state returns to regular.
- R9: Between `pd_enter_i` and `pd_exit_i` no request is made. After exit, the owed refresh is requested within a few cycles.
- R10: `sr_enter_i` disarms the timer, and `pd_exit_i` does not re-arm it. `allref_done_i` re-arms the timer with the due point INTERVAL cycles later and clears any sleep.
- R11: Requests are registered. A cycle in which any feedback or event input is high is followed by a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_idle_i | input | NUM_BANKS | Per-bank idle flag (no queued traffic) |
| bank_open_i | input | NUM_BANKS | Per-bank open-row flag |
| ref_done_i | input | 1 | The requested per-bank refresh was issued |
| pre_done_i | input | 1 | The requested precharge was issued |
| allref_done_i | input | 1 | An all-bank refresh was issued (self-refresh exit) |
| pd_enter_i | input | 1 | Power-down entry issued |
| pd_exit_i | input | 1 | Power-down exit issued |
| sr_enter_i | input | 1 | Self-refresh entry issued |
| req_valid_o | output | 1 | A refresh-related command is requested |
| req_is_ref_o | output | 1 | 1 = per-bank refresh, 0 = precharge |
| req_bank_o | output | $clog2(NUM_BANKS) | Target bank index |
| bank_block_o | output | NUM_BANKS | One-hot block of the bank under forced refresh |

## Verification
A request is decided in the cycle in which the due point is reached and appears on the outputs one edge later. The bench therefore expects the first request after exactly INTERVAL+1 edges from reset release, the forced request after five intervals plus one edge, and a re-armed request INTERVAL+1 edges after the all-bank refresh edge; it samples those outputs on the falling edge just after. Any feedback pulse blanks the request for the edge it is sampled on, so after each pulse the bench checks for a low request and then waits for the next one with a bounded timeout. Effects that have no direct output, such as the return to the regular state on overdue, are exposed by counting how many early refreshes are accepted before the pull-in limit stops them.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

    typedef enum logic {
        ST_REGULAR = 1'b0,
        ST_PULLED  = 1'b1
    } rs_state_e;

    // Decision outcome for one evaluation cycle
    typedef struct packed {
        logic issue;      // raise a request
        logic is_ref;     // refresh (1) or precharge (0)
        logic postpone;   // credit up, due point later
        logic pull_exit;  // leave pulled-in state, due point later
        logic set_hold;   // forced refresh latches its bank
    } rs_act_t;

    // Width of a signed counter spanning [-pull, +post]
    function automatic int credit_bits(input int post, input int pull);
        int m;
        m = (post > pull) ? post : pull;
        return $clog2(m + 1) + 1;
    endfunction

endpackage

// File: rtl/refsched_timer.sv
module refsched_timer #(
    parameter int INTERVAL = 1560
) (
    input  logic clk,
    input  logic rst,
    input  logic rearm_i,
    input  logic disarm_i,
    input  logic advance_i,
    output logic due_o,
    output logic overdue_o
);
    localparam int AW = $clog2(INTERVAL + 1) + 2;
    localparam logic signed [AW-1:0] IV_S  = INTERVAL[AW-1:0];
    localparam logic signed [AW-1:0] ONE_S = {{(AW-1){1'b0}}, 1'b1};

    // age = current cycle minus due point
    logic signed [AW-1:0] age, age_nxt;
    logic                 armed;

    always_comb begin
        age_nxt = age;
        if (armed && (age < IV_S)) age_nxt = age_nxt + ONE_S;
        if (advance_i)             age_nxt = age_nxt - IV_S;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            age   <= -IV_S;
            armed <= 1'b1;
        end else if (rearm_i) begin
            age   <= -IV_S;
            armed <= 1'b1;
        end else if (disarm_i) begin
            armed <= 1'b0;
        end else begin
            age <= age_nxt;
        end
    end

    assign due_o     = armed && !age[AW-1];
    assign overdue_o = armed && (age >= IV_S);

    assert_age_bound_R8: assert property (@(posedge clk) disable iff (rst)
        (age <= IV_S) && (age >= -IV_S));

    assert_disarm_R10: assert property (@(posedge clk) disable iff (rst)
        (disarm_i && !rearm_i) |=> !due_o);

endmodule

// File: rtl/refsched_pending.sv
module refsched_pending #(
    parameter int NB = 8,
    localparam int BW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          remove_i,
    input  logic [BW-1:0] bank_i,
    output logic [NB-1:0] pending_o
);
    logic [NB-1:0] left;

    assign left = pending_o & ~(NB'(1) << bank_i);

    always_ff @(posedge clk) begin
        if (rst)
            pending_o <= '1;
        else if (remove_i)
            pending_o <= (left == '0) ? '1 : left;
    end

    assert_pending_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
        pending_o != '0);

endmodule

// File: rtl/refsched_pick.sv
module refsched_pick #(
    parameter int NB = 8,
    localparam int BW = $clog2(NB)
) (
    input  logic [NB-1:0] pending_i,
    input  logic [NB-1:0] idle_i,
    output logic          any_o,
    output logic [BW-1:0] pick_o,
    output logic [BW-1:0] first_pend_o
);
    // Lowest index wins: scan downwards so later hits override
    always_comb begin
        any_o        = 1'b0;
        pick_o       = '0;
        first_pend_o = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (pending_i[i] && idle_i[i]) begin
                any_o  = 1'b1;
                pick_o = BW'(i);
            end
            if (pending_i[i]) first_pend_o = BW'(i);
        end
    end
endmodule

// File: rtl/bankref_sched.sv
module bankref_sched
    import refsched_pkg::*;
#(
    parameter int NUM_BANKS    = 8,
    parameter int INTERVAL     = 1560,
    parameter int MAX_POSTPONE = 8,
    parameter int MAX_PULLIN   = 8,
    localparam int BW = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_BANKS-1:0] bank_idle_i,
    input  logic [NUM_BANKS-1:0] bank_open_i,
    input  logic                 ref_done_i,
    input  logic                 pre_done_i,
    input  logic                 allref_done_i,
    input  logic                 pd_enter_i,
    input  logic                 pd_exit_i,
    input  logic                 sr_enter_i,
    output logic                 req_valid_o,
    output logic                 req_is_ref_o,
    output logic [BW-1:0]        req_bank_o,
    output logic [NUM_BANKS-1:0] bank_block_o
);
    localparam int POST_LIM = MAX_POSTPONE * NUM_BANKS;
    localparam int PULL_LIM = MAX_PULLIN * NUM_BANKS;
    localparam int CW       = credit_bits(POST_LIM, PULL_LIM);
    localparam logic signed [CW-1:0] POST_C = POST_LIM[CW-1:0];
    localparam logic signed [CW-1:0] PULL_C = -(PULL_LIM[CW-1:0]);
    localparam logic signed [CW-1:0] ONE_C  = {{(CW-1){1'b0}}, 1'b1};

    rs_state_e             state;
    logic signed [CW-1:0]  credit, credit_dec;
    logic                  sleeping, hold;
    logic [BW-1:0]         hold_bank, sel;
    logic [NUM_BANKS-1:0]  pending;
    logic                  any_idle;
    logic [BW-1:0]         pick, first_pend;
    logic                  due, overdue;
    logic                  fb_any, active, do_over, evaluate, forced, at_pull;
    logic                  advance;
    rs_act_t               act;

    refsched_timer #(.INTERVAL(INTERVAL)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .rearm_i   (allref_done_i),
        .disarm_i  (sr_enter_i),
        .advance_i (advance),
        .due_o     (due),
        .overdue_o (overdue)
    );

    refsched_pending #(.NB(NUM_BANKS)) u_pending (
        .clk       (clk),
        .rst       (rst),
        .remove_i  (ref_done_i),
        .bank_i    (req_bank_o),
        .pending_o (pending)
    );

    refsched_pick #(.NB(NUM_BANKS)) u_pick (
        .pending_i    (pending),
        .idle_i       (bank_idle_i),
        .any_o        (any_idle),
        .pick_o       (pick),
        .first_pend_o (first_pend)
    );

    assign fb_any   = ref_done_i | pre_done_i | allref_done_i
                    | pd_enter_i | pd_exit_i | sr_enter_i;
    assign active   = !fb_any && !sleeping;
    assign do_over  = active && overdue;
    assign evaluate = active && !overdue && due;
    assign forced   = (credit == POST_C);

    assign credit_dec = (state == ST_PULLED) ? (credit - ONE_C) : credit;
    assign at_pull    = (credit_dec == PULL_C);

    // Target choice and action for this cycle
    always_comb begin
        act = '0;
        sel = pick;
        if (state == ST_REGULAR) begin
            if (hold)          sel = hold_bank;
            else if (!any_idle) sel = first_pend;
            if (evaluate) begin
                if (!hold && !any_idle && !forced) begin
                    act.postpone = 1'b1;
                end else begin
                    act.issue    = 1'b1;
                    act.is_ref   = !bank_open_i[sel];
                    act.set_hold = forced && !bank_open_i[sel];
                end
            end
        end else if (evaluate) begin
            if (any_idle) begin
                act.issue  = 1'b1;
                act.is_ref = !bank_open_i[sel];
            end else begin
                act.pull_exit = 1'b1;
            end
        end
    end

    assign advance = act.postpone | act.pull_exit | do_over
                   | (ref_done_i && at_pull);

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_REGULAR;
            credit       <= '0;
            sleeping     <= 1'b0;
            hold         <= 1'b0;
            hold_bank    <= '0;
            req_valid_o  <= 1'b0;
            req_is_ref_o <= 1'b0;
            req_bank_o   <= '0;
        end else begin
            req_valid_o  <= act.issue;
            req_is_ref_o <= act.is_ref;
            req_bank_o   <= sel;
            if (act.set_hold) begin
                hold      <= 1'b1;
                hold_bank <= sel;
            end
            if (ref_done_i) begin
                hold   <= 1'b0;
                credit <= credit_dec;
                state  <= at_pull ? ST_REGULAR : ST_PULLED;
            end
            if (act.postpone) credit <= credit + ONE_C;
            if (act.pull_exit || do_over || allref_done_i) state <= ST_REGULAR;
            if (pd_enter_i || sr_enter_i)
                sleeping <= 1'b1;
            else if (pd_exit_i || allref_done_i)
                sleeping <= 1'b0;
        end
    end

    assign bank_block_o = hold ? (NUM_BANKS'(1) << hold_bank) : '0;

    assert_credit_range_R5: assert property (@(posedge clk) disable iff (rst)
        (credit >= PULL_C) && (credit <= POST_C));

    assert_block_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_block_o));

    assert_block_target_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid_o && (bank_block_o != '0)) |-> bank_block_o[req_bank_o]);

    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (hold && !ref_done_i) |=> (hold && $stable(hold_bank)));

    assert_postpone_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (credit > $past(credit)) |-> !req_valid_o);

    assert_sleep_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        sleeping |=> !req_valid_o);

    assert_feedback_gap_R11: assert property (@(posedge clk) disable iff (rst)
        fb_any |=> !req_valid_o);

endmodule

// File: tb/bankref_sched_tb_top.sv
module bankref_sched_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 4;
    localparam int IV = 40;

    // Row: {idle[10:7], open[6:3], bank[2:1], is_ref[0]}
    localparam logic [10:0] VEC [0:6] = '{
        {4'b1111, 4'b0000, 2'd0, 1'b1},
        {4'b1101, 4'b0000, 2'd2, 1'b1},
        {4'b1111, 4'b0010, 2'd1, 1'b0},
        {4'b1111, 4'b0000, 2'd1, 1'b1},
        {4'b1111, 4'b0000, 2'd3, 1'b1},
        {4'b1110, 4'b0000, 2'd1, 1'b1},
        {4'b1111, 4'b0000, 2'd0, 1'b1}
    };

    logic clk = 1'b0;
    logic rst;
    logic [NB-1:0] idle, open_b, block;
    logic ref_done, pre_done, allref, pd_en, pd_ex, sr_en;
    logic req_valid, req_is_ref;
    logic [1:0] req_bank;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bankref_sched #(
        .NUM_BANKS(NB), .INTERVAL(IV), .MAX_POSTPONE(1), .MAX_PULLIN(1)
    ) dut_i (
        .clk(clk), .rst(rst),
        .bank_idle_i(idle), .bank_open_i(open_b),
        .ref_done_i(ref_done), .pre_done_i(pre_done), .allref_done_i(allref),
        .pd_enter_i(pd_en), .pd_exit_i(pd_ex), .sr_enter_i(sr_en),
        .req_valid_o(req_valid), .req_is_ref_o(req_is_ref),
        .req_bank_o(req_bank), .bank_block_o(block)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [NB-1:0] idl);
        rst = 1'b1;
        {ref_done, pre_done, allref, pd_en, pd_ex, sr_en} = '0;
        idle = idl; open_b = '0;
        repeat (3) tick();
        rst = 1'b0;
    endtask

    // 0 ref, 1 pre, 2 allref, 3 pd enter, 4 pd exit, 5 sr enter
    task automatic pulse(input int which);
        case (which)
            0: ref_done = 1'b1;
            1: pre_done = 1'b1;
            2: allref   = 1'b1;
            3: pd_en    = 1'b1;
            4: pd_ex    = 1'b1;
            default: sr_en = 1'b1;
        endcase
        tick();
        {ref_done, pre_done, allref, pd_en, pd_ex, sr_en} = '0;
    endtask

    task automatic wait_req(input int lim, output int n);
        n = 0;
        while (!req_valid && n < lim) begin
            tick();
            n++;
        end
    endtask

    task automatic no_req(input int k, input string tag);
        int bad = 0;
        for (int i = 0; i < k; i++) begin
            tick();
            if (req_valid) bad = 1;
        end
        chk(tag, bad, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int n;
        int cnt;

        // R1: reset state and first due point
        do_reset(4'b1111);
        chk("R1 valid after reset", int'(req_valid), 0);
        chk("R1 block after reset", int'(block), 0);
        repeat (IV) tick();
        chk("R1 no request at due edge", int'(req_valid), 0);
        tick();
        chk("R1 request one edge after due", int'(req_valid), 1);

        // R2/R3/R6/R11: vector walk through a pulled-in round
        for (int r = 0; r < 7; r++) begin
            idle   = VEC[r][10:7];
            open_b = VEC[r][6:3];
            wait_req(3 * IV, n);
            chk("R2 request present", int'(req_valid), 1);
            chk("R2 target bank", int'(req_bank), int'(VEC[r][2:1]));
            chk("R2 refresh or precharge", int'(req_is_ref), int'(VEC[r][0]));
            pulse(VEC[r][0] ? 0 : 1);
            chk("R11 gap after feedback", int'(req_valid), 0);
            if (r == 5) no_req(8, "R6 pull-in limit stops requests");
        end

        // R4/R5/R7: postpone up to the limit, then forced refresh
        do_reset(4'b0000);
        wait_req(6 * IV, n);
        chk("R4 postponed until fifth due point", n, 5 * IV + 1);
        chk("R5 forced bank", int'(req_bank), 0);
        chk("R5 forced is refresh", int'(req_is_ref), 1);
        chk("R5 block set", int'(block), 1);
        idle = 4'b0100;
        repeat (3) tick();
        chk("R5 held bank", int'(req_bank), 0);
        chk("R5 block held", int'(block), 1);
        pulse(0);
        chk("R5 block released", int'(block), 0);
        wait_req(5, n);
        chk("R3 next pending idle bank", int'(req_bank), 2);
        pulse(0);
        idle = 4'b0000;
        no_req(10, "R7 pulled-in all busy exits");

        // R8: overdue returns to regular state -> one extra refresh accepted
        do_reset(4'b1111);
        wait_req(3 * IV, n);
        pulse(0);
        repeat (IV + 5) tick();
        cnt = 0;
        for (int k = 0; k < 10; k++) begin
            wait_req(6, n);
            if (!req_valid) break;
            pulse(0);
            cnt++;
        end
        chk("R8 refreshes after overdue", cnt, 5);

        // R9: power-down suppresses requests
        do_reset(4'b1111);
        pulse(3);
        no_req(2 * IV + 10, "R9 quiet in power-down");
        pulse(4);
        wait_req(6, n);
        chk("R9 request after exit", int'(req_valid), 1);
        chk("R9 bank after exit", int'(req_bank), 0);

        // R10: self-refresh disarms, all-bank refresh re-arms
        do_reset(4'b1111);
        pulse(5);
        pulse(4);
        no_req(3 * IV, "R10 disarmed in self-refresh");
        pulse(2);
        repeat (IV) tick();
        chk("R10 no request at re-armed due edge", int'(req_valid), 0);
        tick();
        chk("R10 request one interval after all-bank refresh", int'(req_valid), 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule